// File: doc/BRIEF.md
# Sixteen-bit multi-cycle processor core

A small 16-bit processor that executes a variable-length instruction stream from one unified memory. It reaches that memory over a single 16-bit address bus, a 16-bit bidirectional data bus and a write strobe. Code and data share the same memory. The core holds a program counter, an instruction register, eight general registers, an adder/subtractor with a zero flag, and a three-way address selector. A control sequencer drives all of these.

Every instruction starts with a fetch cycle. Instructions that need a constant carry it in the memory word directly after the opcode word. That constant is an immediate, a store address or a branch offset. The core is meant to be used with an external memory whose read data is valid in the same cycle as the registered address. Memory writes take effect on the clock edge that ends the cycle in which the write strobe is high.

The opcode word is laid out as follows:

- bits 15:12 hold the operation code.
- bit 11 selects the immediate form.
- bits 10:8 name the destination register.
- bits 7:5 name the source register.
- bits 4:0 are unused.

The operation codes are:

- 0: move.
- 1: add.
- 2: subtract.
- 3: compare.
- 4: store.
- 5: jump if zero.
- 6: jump through register.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight registers and the zero flag, drops the write strobe and places the sequencer in its fetch step, so the address bus shows 0 in the first cycle after reset.
- R2: In a fetch cycle, the address bus equals the program counter and the write strobe is low. The word read is held as the current instruction, and the next cycle presents the program counter plus one.
- R3: Move (code 0) copies the source register into the destination register; with bit 11 set it instead loads the following memory word into the destination.
- R4: Add (code 1) and subtract (code 2, destination minus source) write the 16-bit wrapped result to the destination and set the zero flag exactly when that result is 0; with bit 11 set the second operand is the following memory word.
- R5: Compare (code 3) computes destination minus source (or minus the following word when bit 11 is set), updates the zero flag the same way, and leaves every register unchanged.
- R6: Store (code 4) writes the source register to the absolute address held in the following word: the address appears on the bus with the write strobe high for exactly one cycle while the core drives the data bus.
- R7: Jump-if-zero (code 5) with the zero flag set loads the program counter with the address just after the offset word plus the signed 16-bit offset; an offset of 0xFFFE keeps the core looping on the jump itself with no writes.
- R8: Jump-if-zero with the zero flag clear continues at the word after the offset word.
- R9: Jump through register (code 6) loads the program counter from the source register.
- R10: A loop that adds a counter from 100 down to 1 into an accumulator and stores both leaves 5050 (0x13BA) and 0.
- R11: Operation codes 7 to 15 occupy one word and change no register and no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Registered memory address |
| mem_data | inout | 16 | Memory data; driven by the core only while mem_we is 1 |
| mem_we | output | 1 | Registered write strobe, 1 for a write cycle |

## Verification
A corrupted program counter or sequencer step shows up on the address bus in the following cycle. In that case a fetch address leaves the expected instruction order, or a branch lands on the wrong word. A wrong register value or zero flag stays hidden until a store writes it to memory or a branch decides on it. For this reason, the test programs store each result soon after it is produced and then read back the memory locations. The final summation run also makes errors that only build up over many loop passes visible in its two stored words.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_CMP = 4'd3,
    OP_ST  = 4'd4,
    OP_JZ  = 4'd5,
    OP_JR  = 4'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_WRITE = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    AS_PC     = 2'd0,
    AS_REG    = 2'd1,
    AS_STREAM = 2'd2
  } asel_e;

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [W-1:0]   rdata_a,
  output logic [W-1:0]   rdata_b
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && waddr == RAW'(g)) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         zero
);
  assign res  = sub ? (a - b) : (a + b);
  assign zero = (res == '0);
endmodule

// File: rtl/cpu16_addr_sel.sv
module cpu16_addr_sel
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  asel_e        sel,
  input  logic [W-1:0] pc_val,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] stream_val,
  output logic [W-1:0] addr
);
  always_comb begin
    case (sel)
      AS_REG:    addr = reg_val;
      AS_STREAM: addr = stream_val;
      default:   addr = pc_val;
    endcase
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG),
  localparam int OPW = 4,
  localparam int IMB = W - OPW - 1,
  localparam int DHI = IMB - 1,
  localparam int SHI = DHI - RAW
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  inout  wire  [W-1:0] mem_data,
  output logic         mem_we
);
  state_e         state_q, state_d;
  logic [W-1:0]   pc_q, pc_d, ir_q, wd_q;
  logic           zf_q, zf_d;
  logic           we_d, ir_load, wd_load;
  logic           rf_we;
  logic [W-1:0]   rf_wdata, ra, rb, bus_in, opnd_b, alu_res, nxt_addr;
  logic           alu_zero, alu_sub;
  asel_e          asel;
  op_e            op;
  logic           immf;
  logic [RAW-1:0] dst, src;

  assign bus_in   = mem_data;
  assign mem_data = mem_we ? wd_q : {W{1'bz}};

  assign op     = op_e'(ir_q[W-1 -: OPW]);
  assign immf   = ir_q[IMB];
  assign dst    = ir_q[DHI -: RAW];
  assign src    = ir_q[SHI -: RAW];
  assign opnd_b = immf ? bus_in : rb;
  assign alu_sub = (op != OP_ADD);

  cpu16_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(dst), .wdata(rf_wdata),
    .raddr_a(dst), .raddr_b(src), .rdata_a(ra), .rdata_b(rb)
  );

  cpu16_alu #(.W(W)) u_alu (
    .a(ra), .b(opnd_b), .sub(alu_sub), .res(alu_res), .zero(alu_zero)
  );

  cpu16_addr_sel #(.W(W)) u_asel (
    .sel(asel), .pc_val(pc_d), .reg_val(rb), .stream_val(bus_in), .addr(nxt_addr)
  );

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    zf_d     = zf_q;
    we_d     = 1'b0;
    ir_load  = 1'b0;
    wd_load  = 1'b0;
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    asel     = AS_PC;
    case (state_q)
      ST_FETCH: begin
        ir_load = 1'b1;
        pc_d    = pc_q + 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op)
          OP_MOV: begin
            rf_we    = 1'b1;
            rf_wdata = opnd_b;
            if (immf) pc_d = pc_q + 1'b1;
          end
          OP_ADD, OP_SUB: begin
            rf_we = 1'b1;
            zf_d  = alu_zero;
            if (immf) pc_d = pc_q + 1'b1;
          end
          OP_CMP: begin
            zf_d = alu_zero;
            if (immf) pc_d = pc_q + 1'b1;
          end
          OP_ST: begin
            pc_d    = pc_q + 1'b1;
            asel    = AS_STREAM;
            we_d    = 1'b1;
            wd_load = 1'b1;
            state_d = ST_WRITE;
          end
          OP_JZ: pc_d = zf_q ? (pc_q + 1'b1 + bus_in) : (pc_q + 1'b1);
          OP_JR: begin
            pc_d = rb;
            asel = AS_REG;
          end
          default: ;
        endcase
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      zf_q     <= 1'b0;
      mem_addr <= '0;
      mem_we   <= 1'b0;
      wd_q     <= '0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      zf_q     <= zf_d;
      mem_addr <= nxt_addr;
      mem_we   <= we_d;
      if (ir_load) ir_q <= bus_in;
      if (wd_load) wd_q <= rb;
    end
  end
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_data,
  input logic         mem_we,
  input logic [W-1:0] pc,
  input state_e       state,
  input logic         zf,
  input logic [W-1:0] ir,
  input logic         rf_we
);
  logic is_jz, is_cmp;
  assign is_jz  = (state == ST_EXEC) && (ir[W-1 -: 4] == OP_JZ);
  assign is_cmp = (state == ST_EXEC) && (ir[W-1 -: 4] == OP_CMP);

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (mem_addr == pc && !mem_we)); // R2

  AST_CMP_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    is_cmp |-> !rf_we); // R5

  AST_JZ_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (is_jz && !zf) |=> (pc == $past(pc) + 16'd1)); // R8

  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (is_jz && zf) |=> (pc == $past(pc) + 16'd1 + $past(mem_data))); // R7

  AST_WRITE_LEAVES_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (state == ST_FETCH && mem_addr == pc)); // R6
endmodule

bind cpu16_core cpu16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_we(mem_we), .pc(pc_q), .state(state_q), .zf(zf_q), .ir(ir_q),
  .rf_we(rf_we)
);

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  wire  [15:0] bus;
  logic [15:0] addr;
  logic        we;
  logic [15:0] mem [256];
  int n_chk = 0, n_bad = 0, cyc = 0, wr_cnt = 0, dbl_wr = 0;
  logic prev_we = 1'b0;
  int wp;

  always #2 clk = ~clk;

  cpu16_core uut (.clk(clk), .rst(rst), .mem_addr(addr), .mem_data(bus), .mem_we(we));

  assign bus = we ? 16'bz : mem[addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && we) begin
      mem[addr[7:0]] <= bus;
      wr_cnt <= wr_cnt + 1;
      if (prev_we) dbl_wr <= dbl_wr + 1;
    end
    prev_we <= we && !rst;
  end

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] v;
    logic [7:0]  r;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'h0080, 16'h1234, 8'd3},   // R3 register and immediate move
    '{16'h0081, 16'h000C, 8'd4},   // R4 immediate add
    '{16'h0082, 16'h0000, 8'd7},   // R7 taken skip; R1 register cleared
    '{16'h0083, 16'h0000, 8'd4},   // R4 subtract to zero
    '{16'h0084, 16'h0009, 8'd5},   // R5 compare leaves register
    '{16'h0085, 16'h0055, 8'd8},   // R8 not-taken branch continues
    '{16'h0086, 16'h0055, 8'd11},  // R11 unknown code has no effect
    '{16'h0087, 16'h0055, 8'd9},   // R9 jump through register
    '{16'h0088, 16'hFFFF, 8'd4},   // R4 wrap on subtract
    '{16'h0089, 16'h2468, 8'd4}    // R4 register add
  };

  function automatic logic [15:0] enc(int op, bit im, int d, int s);
    return {op[3:0], im, d[2:0], s[2:0], 5'b0};
  endfunction

  task automatic put(logic [15:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hAAAA;
    wp = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_prog_a();
    clear_mem();
    put(enc(0,1,1,0)); put(16'h1234);
    put(enc(0,0,2,1));
    put(enc(4,0,0,2)); put(16'h0080);
    put(enc(0,1,3,0)); put(16'd5);
    put(enc(1,1,3,0)); put(16'd7);
    put(enc(4,0,0,3)); put(16'h0081);
    put(enc(2,0,3,3));
    put(enc(5,0,0,0)); put(16'd2);
    put(enc(0,1,5,0)); put(16'hDEAD);
    put(enc(4,0,0,5)); put(16'h0082);
    put(enc(4,0,0,3)); put(16'h0083);
    put(enc(0,1,6,0)); put(16'd9);
    put(enc(3,1,6,0)); put(16'd9);
    put(enc(4,0,0,6)); put(16'h0084);
    put(enc(5,0,0,0)); put(16'd2);
    put(enc(0,1,6,0)); put(16'd1);
    put(enc(3,1,6,0)); put(16'd3);
    put(enc(5,0,0,0)); put(16'd2);
    put(enc(0,1,7,0)); put(16'h0055);
    put(enc(4,0,0,7)); put(16'h0085);
    put(enc(15,0,7,7));
    put(enc(4,0,0,7)); put(16'h0086);
    put(enc(0,1,0,0)); put(16'd47);
    put(enc(6,0,0,0));
    put(enc(0,1,7,0)); put(16'h0BAD);
    put(enc(15,0,0,0));
    put(enc(4,0,0,7)); put(16'h0087);
    put(enc(2,1,7,0)); put(16'h0056);
    put(enc(4,0,0,7)); put(16'h0088);
    put(enc(5,0,0,0)); put(16'hFFFE);
    put(enc(1,0,1,1));
    put(enc(4,0,0,1)); put(16'h0089);
    put(enc(3,0,0,0));
    put(enc(5,0,0,0)); put(16'hFFFE);
  endtask

  task automatic load_prog_b();
    clear_mem();
    put(enc(0,1,1,0)); put(16'd100);
    put(enc(0,1,2,0)); put(16'd0);
    put(enc(1,0,2,1));
    put(enc(2,1,1,0)); put(16'd1);
    put(enc(5,0,0,0)); put(16'd3);
    put(enc(0,1,4,0)); put(16'd4);
    put(enc(6,0,0,4));
    put(enc(4,0,0,2)); put(16'h0090);
    put(enc(4,0,0,1)); put(16'h0091);
    put(enc(3,0,0,0));
    put(enc(5,0,0,0)); put(16'hFFFE);
  endtask

  initial begin : watchdog
    wait (cyc > 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<=20000", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    load_prog_a();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 addr in reset", addr, 16'h0000);
    chk("R1 we in reset", {15'b0, we}, 16'h0000);
    rst = 1'b0;
    chk("R2 first fetch addr", addr, 16'h0000);
    @(negedge clk);
    chk("R2 operand addr after fetch", addr, 16'h0001);
    @(negedge clk);
    chk("R2 next fetch addr", addr, 16'h0002);
    chk("R2 we low on read", {15'b0, we}, 16'h0000);

    repeat (400) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      n_chk++;
      if (mem[VECS[k].a[7:0]] !== VECS[k].v) begin
        n_bad++;
        $display("FAIL R%0d at %h actual=%h expected=%h",
                 VECS[k].r, VECS[k].a, mem[VECS[k].a[7:0]], VECS[k].v);
      end
    end
    chk("R6 store count", 16'(wr_cnt), 16'd10);
    chk("R6 single-cycle strobe", 16'(dbl_wr), 16'd0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n_chk++;
      if (!(addr == 16'd59 || addr == 16'd60) || we) begin
        n_bad++;
        $display("FAIL R7 self loop actual=%h expected=003b/003c", addr);
      end
    end
    chk("R6 R7 no writes in loop", 16'(wr_cnt), 16'd10);

    load_prog_b();
    do_reset();
    repeat (3000) @(negedge clk);
    chk("R10 sum", mem[8'h90], 16'h13BA);
    chk("R10 counter", mem[8'h91], 16'h0000);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule